// File: doc/BRIEF.md
# Saturating Bidirectional Arithmetic Shifter

This block shifts a signed fixed-point word by a signed count. A positive count shifts left and a negative count shifts right by its magnitude. The word is either a short (16-bit) or a long (32-bit) operand, chosen per request. Left shifts never wrap. When the true result does not fit the operand width, the output clamps to the largest positive or most negative value, and an overflow flag is raised with it. Right shifts are arithmetic, so the sign bit fills in from the top. An optional rounding flag turns a right shift into a rounded one: the last bit shifted out is added back to the result.

A request strobe captures one operation. The result, the overflow flag and a valid pulse appear on the registered outputs one clock later. The outputs hold their values until the next request. In short mode, only the low half of the data input is used, and the result is returned sign-extended to the full output width.

Top module: `sat_shift_unit`

## Requirements
- R1: `count_i` is a two's-complement number. A positive value shifts left by that many places, a negative value shifts right by its magnitude, and zero returns the operand unchanged with no overflow.
- R2: When `long_i` is 0, the operand is the signed value in `data_i[15:0]`. Bits `data_i[31:16]` have no effect, and `result_o` is the 16-bit result sign-extended to 32 bits.
- R3: In short mode, a left shift by 16 or more places of a nonzero operand, or any left shift whose exact result falls outside -32768..32767, returns 0x00007FFF for a positive operand and 0xFFFF8000 for a negative one.
- R4: In long mode, a left shift whose exact result falls outside the signed 32-bit range returns 0x7FFFFFFF for a positive operand and 0x80000000 for a negative one. A nonzero operand shifted by 32 or more places always clamps.
- R5: A zero operand gives a zero result with `ovf_o` low, in every mode and for every count.
- R6: An unrounded right shift by magnitude n is arithmetic. For n of 15 or more (short) or 31 or more (long), the result is -1 for a negative operand and 0 otherwise.
- R7: With `round_i` high and a right-shift magnitude n from 1 to 15 (short) or 1 to 31 (long), the result is the arithmetic shift plus bit n-1 of the operand.
- R8: With `round_i` high, a right-shift magnitude above 15 (short) or above 31 (long) returns 0. `round_i` has no effect on left shifts or on a zero count.
- R9: `ovf_o` is high exactly when the registered result is a clamped value from R3 or R4. It is low for every right shift.
- R10: `valid_o` is high in the cycle after a cycle with `req_i` high and low otherwise. `result_o` and `ovf_o` change only in the cycle after a request.
- R11: While `rst_n` is low, `valid_o`, `ovf_o` and `result_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Captures one operation this cycle |
| long_i | input | 1 | 1 selects a 32-bit operand, 0 a 16-bit operand |
| round_i | input | 1 | Rounds right shifts |
| count_i | input | 7 | Signed shift count; positive shifts left |
| data_i | input | 32 | Operand; only bits 15:0 in short mode |
| result_o | output | 32 | Shifted, saturated or rounded result |
| ovf_o | output | 1 | Result was clamped |
| valid_o | output | 1 | Result registered from last cycle's request |

## Verification
The only state in this block is the output register stage. A fault there shows at the ports on the very next cycle after a request, or during an idle cycle, as a wrong valid pulse or a result that drifts while idle.

A fault in the shift logic shows as a wrong result or overflow flag on the cycle after the request that exposes it. The sweeps therefore cover:
- every count in both modes, with and without rounding;
- operands of widely varied magnitude, including the extremes and zero.

Clamp thresholds, the rounding bit position and sign fill are each visible on the first offending request.

// File: rtl/sat_shift_pkg.sv
package sat_shift_pkg;
  typedef enum logic {
    DIR_LEFT  = 1'b0,
    DIR_RIGHT = 1'b1
  } shift_dir_e;
endpackage

// File: rtl/shift_count_dec.sv
module shift_count_dec
  import sat_shift_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic [CW-1:0] count,
  output shift_dir_e    dir,
  output logic [CW:0]   mag
);
  logic [CW:0] ext;

  always_comb begin
    ext = {count[CW-1], count};
    if (count[CW-1]) begin
      dir = DIR_RIGHT;
      mag = ~ext + 1'b1;
    end else begin
      dir = DIR_LEFT;
      mag = ext;
    end
  end
endmodule

// File: rtl/sat_shift_lane.sv
module sat_shift_lane
  import sat_shift_pkg::*;
#(
  parameter int W  = 16,
  parameter int MW = 8
) (
  input  logic [W-1:0]  x,
  input  shift_dir_e    dir,
  input  logic [MW-1:0] mag,
  input  logic          rnd,
  output logic [W-1:0]  y,
  output logic          ovf
);
  localparam int AW = $clog2(W);
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MAX = {1'b1, {(W-1){1'b0}}};

  logic          big;
  logic [AW-1:0] amt;
  logic [AW-1:0] amt_m1;
  logic [2*W-1:0] wide;
  logic [W:0]    top;
  logic          fits;
  logic          left_ovf;
  logic [W-1:0]  sr;
  logic          rbit;

  always_comb begin
    big      = (mag >= MW'(W));
    amt      = big ? AW'(W - 1) : mag[AW-1:0];
    amt_m1   = amt - 1'b1;
    wide     = {{W{x[W-1]}}, x} << mag[AW-1:0];
    top      = wide[2*W-1:W-1];
    fits     = (&top) | ~(|top);
    left_ovf = (|x) & (big | ~fits);
    sr       = W'($signed(x) >>> amt);
    rbit     = (mag != '0) & ~big & x[amt_m1];
    ovf      = 1'b0;
    if (dir == DIR_LEFT) begin
      ovf = left_ovf;
      y   = left_ovf ? (x[W-1] ? NEG_MAX : POS_MAX) : wide[W-1:0];
    end else if (rnd) begin
      y = big ? '0 : sr + W'(rbit);
    end else begin
      y = sr;
    end
  end
endmodule

// File: rtl/sat_shift_unit.sv
module sat_shift_unit
  import sat_shift_pkg::*;
#(
  parameter int SW = 16,
  parameter int LW = 32,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          long_i,
  input  logic          round_i,
  input  logic [CW-1:0] count_i,
  input  logic [LW-1:0] data_i,
  output logic [LW-1:0] result_o,
  output logic          ovf_o,
  output logic          valid_o
);
  localparam int MW = CW + 1;

  shift_dir_e    dir;
  logic [MW-1:0] mag;
  logic [SW-1:0] s_y;
  logic          s_ovf;
  logic [LW-1:0] l_y;
  logic          l_ovf;

  logic [LW-1:0] result_d;
  logic          ovf_d;
  logic          upd_en;

  shift_count_dec #(.CW(CW)) u_dec (
    .count (count_i),
    .dir   (dir),
    .mag   (mag)
  );

  sat_shift_lane #(.W(SW), .MW(MW)) u_short (
    .x   (data_i[SW-1:0]),
    .dir (dir),
    .mag (mag),
    .rnd (round_i),
    .y   (s_y),
    .ovf (s_ovf)
  );

  sat_shift_lane #(.W(LW), .MW(MW)) u_long (
    .x   (data_i),
    .dir (dir),
    .mag (mag),
    .rnd (round_i),
    .y   (l_y),
    .ovf (l_ovf)
  );

  always_comb begin
    upd_en = req_i;
    if (long_i) begin
      result_d = l_y;
      ovf_d    = l_ovf;
    end else begin
      result_d = {{(LW-SW){s_y[SW-1]}}, s_y};
      ovf_d    = s_ovf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      ovf_o    <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= req_i;
      if (upd_en) begin
        result_o <= result_d;
        ovf_o    <= ovf_d;
      end
    end
  end
endmodule

// File: rtl/sat_shift_unit_chk.sv
module sat_shift_unit_chk #(
  parameter int SW = 16,
  parameter int LW = 32,
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_i,
  input logic          long_i,
  input logic          round_i,
  input logic [CW-1:0] count_i,
  input logic [LW-1:0] data_i,
  input logic [LW-1:0] result_o,
  input logic          ovf_o,
  input logic          valid_o
);
  localparam logic [LW-1:0] L_POS = {1'b0, {(LW-1){1'b1}}};
  localparam logic [LW-1:0] L_NEG = {1'b1, {(LW-1){1'b0}}};
  localparam logic [LW-1:0] S_POS = LW'({1'b0, {(SW-1){1'b1}}});
  localparam logic [LW-1:0] S_NEG = {{(LW-SW+1){1'b1}}, {(SW-1){1'b0}}};

  logic zero_in;
  assign zero_in = long_i ? (data_i == '0) : (data_i[SW-1:0] == '0);

  // R10: valid follows the request by one cycle
  assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> valid_o);
  assert_valid_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !valid_o);
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> ($stable(result_o) && $stable(ovf_o)));

  // R9: overflow only with a clamped value
  assert_ovf_clamped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (result_o == L_POS || result_o == L_NEG ||
               result_o == S_POS || result_o == S_NEG));
  assert_right_no_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && count_i[CW-1]) |=> !ovf_o);

  // R5: zero operand
  assert_zero_in_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && zero_in) |=> (result_o == '0 && !ovf_o));

  // R2: short result is sign-extended
  assert_short_sext_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !long_i) |=> ((&result_o[LW-1:SW-1]) || !(|result_o[LW-1:SW-1])));

  // R1: zero count passes the long operand through
  assert_zero_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && long_i && count_i == '0) |=> (result_o == $past(data_i) && !ovf_o));
endmodule

bind sat_shift_unit sat_shift_unit_chk #(.SW(SW), .LW(LW), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_i    (req_i),
  .long_i   (long_i),
  .round_i  (round_i),
  .count_i  (count_i),
  .data_i   (data_i),
  .result_o (result_o),
  .ovf_o    (ovf_o),
  .valid_o  (valid_o)
);

// File: tb/sat_shift_unit_bench.sv
module sat_shift_unit_bench;
  localparam int NDATA = 150;

  logic        clk;
  logic        rst_n;
  logic        req_i;
  logic        long_i;
  logic        round_i;
  logic [6:0]  count_i;
  logic [31:0] data_i;
  logic [31:0] result_o;
  logic        ovf_o;
  logic        valid_o;

  int checks;
  int fails;
  bit done;

  sat_shift_unit u_sat_shift_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .long_i   (long_i),
    .round_i  (round_i),
    .count_i  (count_i),
    .data_i   (data_i),
    .result_o (result_o),
    .ovf_o    (ovf_o),
    .valid_o  (valid_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void model(input bit lng, input bit rnd, input logic [31:0] d,
                                input int c, output logic [31:0] r, output bit ov);
    int w;
    int n;
    longint x;
    longint mx;
    longint mn;
    longint p;
    w  = lng ? 32 : 16;
    x  = lng ? longint'($signed(d)) : longint'($signed(d[15:0]));
    mx = (longint'(1) << (w - 1)) - 1;
    mn = -mx - 1;
    ov = 1'b0;
    if (c >= 0) begin
      if (x == 0) p = 0;
      else if (c >= w) begin
        p  = (x > 0) ? mx : mn;
        ov = 1'b1;
      end else begin
        p = x * (longint'(1) << c);
        if (p > mx || p < mn) begin
          p  = (x > 0) ? mx : mn;
          ov = 1'b1;
        end
      end
    end else begin
      n = -c;
      if (rnd) begin
        if (n > w - 1) p = 0;
        else p = (x >>> n) + ((x >>> (n - 1)) & 1);
      end else begin
        p = x >>> ((n > w - 1) ? (w - 1) : n);
      end
    end
    r = 32'(p);
  endfunction

  function automatic string tag_of(input bit lng, input bit rnd, input logic [31:0] d,
                                   input int c, input bit ov);
    int w;
    w = lng ? 32 : 16;
    if (ov) return lng ? "R4" : "R3";
    if ((lng && d == 0) || (!lng && d[15:0] == 0)) return "R5";
    if (c == 0) return lng ? "R1" : "R2";
    if (c > 0) return "R1";
    if (!rnd) return "R6";
    if (-c > w - 1) return "R8";
    return "R7";
  endfunction

  function automatic logic [31:0] gen(input bit lng, input int i);
    logic [31:0] h;
    logic [15:0] sv;
    h = (i * 32'h9E3779B1) ^ (i << 7) ^ 32'h5A5A0F0F;
    if (lng) begin
      case (i)
        0: return 32'h0;
        1: return 32'h1;
        2: return 32'hFFFFFFFF;
        3: return 32'h7FFFFFFF;
        4: return 32'h80000000;
        5: return 32'h40000000;
        6: return 32'hC0000000;
        default: return 32'($signed(h) >>> (i % 32));
      endcase
    end else begin
      case (i)
        0: sv = 16'h0;
        1: sv = 16'h1;
        2: sv = 16'hFFFF;
        3: sv = 16'h7FFF;
        4: sv = 16'h8000;
        5: sv = 16'h4000;
        6: sv = 16'hC000;
        default: sv = 16'($signed(h[15:0]) >>> (i % 16));
      endcase
      return {h[31:16] ^ 16'hA5A5, sv};
    end
  endfunction

  initial begin
    #1200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] er;
    logic [31:0] held;
    bit eo;
    checks  = 0;
    fails   = 0;
    done    = 1'b0;
    rst_n   = 1'b0;
    req_i   = 1'b0;
    long_i  = 1'b0;
    round_i = 1'b0;
    count_i = '0;
    data_i  = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 result", result_o, 32'h0);
    check("R11 ovf", {31'b0, ovf_o}, 32'h0);
    check("R11 valid", {31'b0, valid_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int lng = 0; lng < 2; lng++) begin
      for (int rnd = 0; rnd < 2; rnd++) begin
        for (int c = -64; c < 64; c++) begin
          for (int i = 0; i < NDATA; i++) begin
            req_i   = 1'b1;
            long_i  = lng[0];
            round_i = rnd[0];
            count_i = 7'(c);
            data_i  = gen(lng[0], i);
            model(lng[0], rnd[0], data_i, c, er, eo);
            @(negedge clk);
            check(tag_of(lng[0], rnd[0], data_i, c, eo), result_o, er);
            check("R9 ovf", {31'b0, ovf_o}, {31'b0, eo});
            check("R10 valid", {31'b0, valid_o}, 32'h1);
          end
        end
      end
    end

    // R10: idle cycles keep the outputs and drop valid
    req_i = 1'b0;
    held  = result_o;
    data_i  = 32'h12345678;
    count_i = 7'd3;
    @(negedge clk);
    check("R10 idle valid", {31'b0, valid_o}, 32'h0);
    check("R10 idle hold", result_o, held);
    @(negedge clk);
    check("R10 idle hold2", result_o, held);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule